// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block gathers the data bytes of one page-program command for a flash with 128-byte pages and then writes them into a byte-array model of the flash. A command opens with a start strobe carrying the target address. Data bytes then arrive one per strobe. The command closes with either a commit, which stands for a valid deselect after whole bytes, or an abort. Byte placement wraps inside the addressed page, so a long burst overwrites its own earlier bytes. A 128-bit mark vector records which page offsets received data. On commit, a walker visits every offset of the page, one per clock. At each marked offset it ANDs the buffered byte into the array, so programming can only clear bits.

The same block also erases the array model. A sector erase fills one quarter of the array with FFh. A bulk erase fills the whole array with FFh. A registered read port returns array contents, and `busy` is high while a commit walk or an erase walk is running.

The control is a four-state machine:
- IDLE (waiting). It moves to FILL on `cmd_start`. Otherwise it moves to ERASE on `erase_all` or `erase_sector`.
- FILL (collecting bytes). It moves back to IDLE on `cmd_abort`. On `cmd_commit` it moves to PROG if at least one byte was marked, and back to IDLE if none was.
- PROG (commit walk). It moves to IDLE after offset 127.
- ERASE (erase walk). It moves to IDLE after the last address of the erase range.

The default geometry is 2048 bytes: 16 pages of 128 bytes and 4 sectors of 512 bytes. Setting `ADDR_W` to 17 gives the full 131,072-byte part with 1,024 pages and 32 KB sectors.

Top module: `page_program_engine`

## Requirements
- R1: After reset every array byte reads FFh and `busy` is 0.
- R2: The first data byte of a command lands at page offset `cmd_addr[6:0]` of page `cmd_addr[10:7]`. Each further byte lands at the next offset.
- R3: An offset past 7Fh wraps to 00h of the same page. No byte ever reaches a neighbouring page.
- R4: If more than 128 bytes arrive, byte k goes to offset (start + k) mod 128 and a later byte replaces an earlier one at the same offset. Only the last 128 bytes are programmed.
- R5: Offsets that received no byte in the command keep their previous array value after the commit.
- R6: A committed byte becomes (old value AND new byte), so programming never turns a 0 bit into 1.
- R7: `cmd_abort` during FILL returns the block to IDLE without `busy` and without changing the array.
- R8: `cmd_commit` with no data byte received returns the block to IDLE, leaves `busy` at 0 and changes nothing.
- R9: After a commit with data, `busy` is high for exactly 128 clock cycles, starting with the cycle after the commit strobe.
- R10: `erase_sector` selects the sector by `cmd_addr[10:9]`, whatever the other address bits are. It sets all 512 bytes of that sector to FFh, leaves the other sectors untouched, and holds `busy` for 512 cycles.
- R11: `erase_all` sets every array byte to FFh and holds `busy` for 2048 cycles. When both erase strobes arrive together, `erase_all` wins.
- R12: While `busy` is high, `cmd_start`, `din_valid`, `cmd_commit`, `cmd_abort` and both erase strobes are ignored.
- R13: `rd_data` shows the array byte at the `rd_addr` value sampled on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Opens a program command, taken only in IDLE |
| cmd_addr | input | ADDR_W | Start address for program, or address inside the sector to erase |
| din_valid | input | 1 | Strobe for one data byte during FILL |
| din_byte | input | 8 | Data byte |
| cmd_commit | input | 1 | Valid deselect that closes the command |
| cmd_abort | input | 1 | Invalid deselect that drops the command |
| erase_sector | input | 1 | Starts a sector erase, taken only in IDLE |
| erase_all | input | 1 | Starts a bulk erase, taken only in IDLE |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High during commit and erase walks |

## Verification
The assertions assume that each strobe is held for exactly one clock, that `cmd_commit` and `cmd_abort` are never raised together, and that a command is closed before a new one opens. The bench drives every strobe for a single cycle from the falling edge and clears it on the next falling edge. It only opens a new command after `busy` has dropped, except in the one test that raises every strobe on purpose in the middle of a walk.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } pgb_state_e;

    typedef enum logic {
        WR_PROGRAM = 1'b0,
        WR_ERASE   = 1'b1
    } pgb_wr_kind_e;

endpackage

// File: rtl/pgb_page_buffer.sv
module pgb_page_buffer #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_off,
    input  logic              push,
    input  logic [7:0]        push_byte,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic              rd_mark,
    output logic              any_marked
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_q;
    logic [PAGE_W-1:0]     off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            mark_q <= '0;
            off_q  <= load_off;
        end else if (push) begin
            mark_q[off_q] <= 1'b1;
            off_q         <= off_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !load) begin
            data_q[off_q] <= push_byte;
        end
    end

    assign rd_byte    = data_q[rd_idx];
    assign rd_mark    = mark_q[rd_idx];
    assign any_marked = |mark_q;

    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load && (&off_q)) |=> (off_q == '0)); // R3

    AST_MASK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> (mark_q[$past(off_q)] && any_marked)); // R5

endmodule

// File: rtl/pgb_byte_array.sv
module pgb_byte_array
    import pgb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  pgb_wr_kind_e      kind,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
            rdata <= 8'hFF;
        end else begin
            rdata <= mem_q[raddr];
            if (we) begin
                if (kind == WR_ERASE) begin
                    mem_q[waddr] <= 8'hFF;
                end else begin
                    mem_q[waddr] <= mem_q[waddr] & wdata;
                end
            end
        end
    end

endmodule

// File: rtl/page_program_engine.sv
module page_program_engine
    import pgb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_W     = 7,
    parameter int SECT_SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              din_valid,
    input  logic [7:0]        din_byte,
    input  logic              cmd_commit,
    input  logic              cmd_abort,
    input  logic              erase_sector,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PAGE_NUM_W = ADDR_W - PAGE_W;
    localparam int SECT_OFF_W = ADDR_W - SECT_SEL_W;

    pgb_state_e state_q, state_d;

    logic [PAGE_NUM_W-1:0] page_q;
    logic [PAGE_W-1:0]     widx_q;
    logic [ADDR_W-1:0]     eaddr_q;
    logic [ADDR_W-1:0]     elast_q;

    logic                  buf_load;
    logic                  buf_push;
    logic [7:0]            buf_byte;
    logic                  buf_mark;
    logic                  buf_any;

    logic                  mem_we;
    pgb_wr_kind_e          mem_kind;
    logic [ADDR_W-1:0]     mem_waddr;

    logic [SECT_SEL_W-1:0] sect_sel;
    assign sect_sel = cmd_addr[ADDR_W-1 -: SECT_SEL_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    state_d = ST_FILL;
                end else if (erase_all || erase_sector) begin
                    state_d = ST_ERASE;
                end
            end
            ST_FILL: begin
                if (cmd_abort) begin
                    state_d = ST_IDLE;
                end else if (cmd_commit) begin
                    state_d = buf_any ? ST_PROG : ST_IDLE;
                end
            end
            ST_PROG: begin
                if (&widx_q) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (eaddr_q == elast_q) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // walk counters and latched command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            widx_q  <= '0;
            eaddr_q <= '0;
            elast_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        page_q <= cmd_addr[ADDR_W-1:PAGE_W];
                        widx_q <= '0;
                    end else if (erase_all) begin
                        eaddr_q <= '0;
                        elast_q <= '1;
                    end else if (erase_sector) begin
                        eaddr_q <= {sect_sel, {SECT_OFF_W{1'b0}}};
                        elast_q <= {sect_sel, {SECT_OFF_W{1'b1}}};
                    end
                end
                ST_FILL: begin
                    widx_q <= '0;
                end
                ST_PROG: begin
                    widx_q <= widx_q + 1'b1;
                end
                ST_ERASE: begin
                    eaddr_q <= eaddr_q + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        buf_load  = 1'b0;
        buf_push  = 1'b0;
        mem_we    = 1'b0;
        mem_kind  = WR_PROGRAM;
        mem_waddr = {page_q, widx_q};
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                buf_load = cmd_start;
            end
            ST_FILL: begin
                buf_push = din_valid && !cmd_commit && !cmd_abort;
            end
            ST_PROG: begin
                busy   = 1'b1;
                mem_we = buf_mark;
            end
            ST_ERASE: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_kind  = WR_ERASE;
                mem_waddr = eaddr_q;
            end
        endcase
    end

    pgb_page_buffer #(
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (buf_load),
        .load_off   (cmd_addr[PAGE_W-1:0]),
        .push       (buf_push),
        .push_byte  (din_byte),
        .rd_idx     (widx_q),
        .rd_byte    (buf_byte),
        .rd_mark    (buf_mark),
        .any_marked (buf_any)
    );

    pgb_byte_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .kind  (mem_kind),
        .waddr (mem_waddr),
        .wdata (buf_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_ABORT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cmd_abort) |=> (state_q == ST_IDLE && !busy)); // R7

    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !cmd_abort && cmd_commit && !buf_any) |=> !busy); // R8

    AST_WALK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !(&widx_q)) |=> (state_q == ST_PROG)); // R9

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(page_q)); // R12

    AST_ERASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> (eaddr_q <= elast_q)); // R10

endmodule

// File: tb/page_program_engine_test.sv
module page_program_engine_test;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NROWS  = 10;

    // row: {op[1:0], addr[10:0], count[8:0], seed[7:0]}
    // op 0 program, 1 program then abort, 2 sector erase, 3 bulk erase
    localparam logic [29:0] ROWS [NROWS] = '{
        {2'd0, 11'h005, 9'd10,  8'h3C},  // R2 R5
        {2'd0, 11'h07A, 9'd12,  8'hA5},  // R3 wrap inside page 0
        {2'd0, 11'h105, 9'd200, 8'h71},  // R4 overflow keeps last 128
        {2'd0, 11'h005, 9'd10,  8'hC3},  // R6 AND over row 0
        {2'd1, 11'h300, 9'd20,  8'h00},  // R7 abort
        {2'd2, 11'h0F3, 9'd0,   8'h00},  // R10 sector 0, odd address
        {2'd0, 11'h6FF, 9'd130, 8'h19},  // R3 R4 page 13
        {2'd2, 11'h7AB, 9'd0,   8'h00},  // R10 sector 3
        {2'd3, 11'h000, 9'd0,   8'h00},  // R11 bulk
        {2'd0, 11'h280, 9'd128, 8'h5E}   // R2 full page
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              din_valid = 1'b0;
    logic [7:0]        din_byte = '0;
    logic              cmd_commit = 1'b0;
    logic              cmd_abort = 1'b0;
    logic              erase_sector = 1'b0;
    logic              erase_all = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model_mem [DEPTH];

    always #2.5 clk = ~clk;

    page_program_engine uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_addr     (cmd_addr),
        .din_valid    (din_valid),
        .din_byte     (din_byte),
        .cmd_commit   (cmd_commit),
        .cmd_abort    (cmd_abort),
        .erase_sector (erase_sector),
        .erase_all    (erase_all),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .busy         (busy)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return seed ^ 8'(k * 29) ^ 8'(k >> 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        int first_a = -1;
        int first_v = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a);
            @(negedge clk);
            if (rd_data != model_mem[a]) begin
                if (first_a < 0) begin
                    first_a = a;
                    first_v = int'(rd_data);
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: %0d bytes differ, first at %0h actual %0h expected %0h",
                     req, bad, first_a, first_v, model_mem[first_a]);
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_program(input logic [ADDR_W-1:0] addr, input int cnt,
                               input logic [7:0] seed, input bit drop);
        logic [7:0] pb [128];
        bit         pm [128];
        int n;
        for (int o = 0; o < 128; o++) begin
            pm[o] = 1'b0;
            pb[o] = 8'h00;
        end
        cmd_start = 1'b1;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            din_valid = 1'b1;
            din_byte  = pat(seed, k);
            pb[(int'(addr[6:0]) + k) % 128] = pat(seed, k);
            pm[(int'(addr[6:0]) + k) % 128] = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        if (drop) cmd_abort = 1'b1;
        else      cmd_commit = 1'b1;
        @(negedge clk);
        cmd_abort  = 1'b0;
        cmd_commit = 1'b0;
        count_busy(n);
        if (drop || cnt == 0) begin
            check("R7 R8 no walk", n, 0);
        end else begin
            check("R9 walk length", n, 128);
            for (int o = 0; o < 128; o++) begin
                if (pm[o]) model_mem[{addr[10:7], 7'(o)}] &= pb[o];
            end
        end
    endtask

    task automatic run_erase(input logic [ADDR_W-1:0] addr, input bit whole);
        int n;
        if (whole) erase_all = 1'b1;
        else       erase_sector = 1'b1;
        cmd_addr = addr;
        @(negedge clk);
        erase_all    = 1'b0;
        erase_sector = 1'b0;
        count_busy(n);
        if (whole) begin
            check("R11 bulk busy length", n, DEPTH);
            for (int a = 0; a < DEPTH; a++) model_mem[a] = 8'hFF;
        end else begin
            check("R10 sector busy length", n, DEPTH / 4);
            for (int a = 0; a < DEPTH / 4; a++) model_mem[{addr[10:9], 9'(a)}] = 8'hFF;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < DEPTH; a++) model_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy after reset", int'(busy), 0);
        compare_all("R1 array after reset");

        // table walk
        for (int r = 0; r < NROWS; r++) begin
            logic [1:0]        op;
            logic [ADDR_W-1:0] ad;
            int                cnt;
            logic [7:0]        sd;
            op  = ROWS[r][29:28];
            ad  = ROWS[r][27:17];
            cnt = int'(ROWS[r][16:8]);
            sd  = ROWS[r][7:0];
            case (op)
                2'd0: begin
                    run_program(ad, cnt, sd, 1'b0);
                    compare_all("R2 R3 R4 R5 R6 program result");
                end
                2'd1: begin
                    run_program(ad, cnt, sd, 1'b1);
                    compare_all("R7 abort leaves array");
                end
                2'd2: begin
                    run_erase(ad, 1'b0);
                    compare_all("R10 sector erase");
                end
                default: begin
                    run_erase(ad, 1'b1);
                    compare_all("R11 bulk erase");
                end
            endcase
        end

        // R8 commit with no data
        cmd_start = 1'b1;
        cmd_addr  = 11'h500;
        @(negedge clk);
        cmd_start  = 1'b0;
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
        check("R8 busy after empty commit", int'(busy), 0);
        compare_all("R8 empty commit leaves array");

        // R12 strobes ignored during a walk
        run_program(11'h410, 0, 8'h00, 1'b0);
        cmd_start = 1'b1;
        cmd_addr  = 11'h410;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            din_valid = 1'b1;
            din_byte  = pat(8'h92, k);
            @(negedge clk);
        end
        din_valid  = 1'b0;
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cmd_start  = 1'b1;
        cmd_addr   = 11'h000;
        erase_all  = 1'b1;
        cmd_abort  = 1'b1;
        cmd_commit = 1'b1;
        din_valid  = 1'b1;
        din_byte   = 8'h00;
        @(negedge clk);
        cmd_start  = 1'b0;
        erase_all  = 1'b0;
        cmd_abort  = 1'b0;
        cmd_commit = 1'b0;
        din_valid  = 1'b0;
        count_busy(n);
        check("R12 walk unaffected by strobes", n + 3, 128);
        for (int k = 0; k < 5; k++) model_mem[11'h410 + k] &= pat(8'h92, k);
        compare_all("R12 array after ignored strobes");

        // R13 read latency of one cycle
        rd_addr = 11'h280;
        @(negedge clk);
        check("R13 read data", int'(rd_data), int'(model_mem[11'h280]));
        rd_addr = 11'h281;
        #1;
        check("R13 data held until edge", int'(rd_data), int'(model_mem[11'h280]));
        @(negedge clk);
        check("R13 next address", int'(rd_data), int'(model_mem[11'h281]));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule